// File: doc/BRIEF.md
# Twisted-Pair Link Integrity and Receive Polarity Monitor

This block keeps track of the health of one 10BASE-T twisted-pair port. It is fed with receive events that a front end has already digitised: a link pulse was detected, together with the raw line polarity it showed, or a packet ended on a valid end-of-transmit delimiter, together with that delimiter's raw polarity. From these events it decides whether the link is up. It also decides whether the receive pair is wired backwards. In the same way it watches the port's own transmit activity and asks for an outgoing link pulse whenever the transmitter has been quiet for too long.

A port that has been silent for longer than the fail window drops into link fail, and its transmit and receive paths are then inhibited. Two things bring it back: a received packet, or a run of identical-polarity link pulses. Whichever one restores the link also sets the polarity correction. While the link is up, and a packet with a valid delimiter ends before polarity has been settled, that packet sets the correction once. After that, only pulses that arrive in the true orientation count as activity. Every timer is a parameter expressed in clock ticks. The defaults assume a 20 MHz clock: 16 ms of transmit idle and a 90 ms receive window.

Top module: `link_integrity_monitor`

## Requirements
- R1: While `rst_n` is low on a clock edge, the block goes to link fail. The outputs are then `link_pass`=0, `trx_enable`=0, `pol_correct`=1 and `lp_tx_req`=0. Polarity detection is armed.
- R2: `lp_tx_req` goes high for exactly one cycle after `IDLE_TICKS` consecutive clock edges at which `tx_active` was low and `cfg_pulse_tx_en` was high. The count then restarts. A clock edge with `tx_active` high sets the count back to zero.
- R3: Link pulse requests carry on while the port is in link fail. While `cfg_pulse_tx_en` is low, no request is made and the idle count is held at zero.
- R4: The port is in link pass with link test enabled. If `FAIL_TICKS` consecutive clock edges pass without valid receive activity, it enters link fail, and `link_pass` and `trx_enable` both drop.
- R5: In link fail, pulses of either polarity are counted. The port enters link pass on the cycle after the `PULSE_THRESH`-th consecutive pulse of the same raw polarity (default 6). A pulse whose polarity differs from the one before it restarts the run at 1.
- R6: In link fail, a packet-end event brings the port back to link pass on the next cycle.
- R7: When link pass is reached through a pulse run and auto-polarity is enabled, the correction takes the run's raw polarity. `rx_pulse_neg`=1 (inverted) gives `pol_correct`=0, meaning the receive path is inverted.
- R8: Polarity is armed after reset and on every entry to link fail. The first packet end seen while armed sets `pol_correct` to the inverse of `rx_pkt_neg` and disarms. Later packet ends leave polarity unchanged.
- R9: In link pass, a link pulse resets the silence window only if its raw polarity matches the current correction (`rx_pulse_neg` equal to `!pol_correct`). Any other pulse is ignored. A packet end always resets the window.
- R10: While `cfg_link_test_en` is low, `link_pass` and `trx_enable` read 1 in the same cycle, whatever happens on the line.
- R11: While `cfg_auto_pol_en` is low, `pol_correct` is 1 from the next edge on. Leaving link fail works as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_link_test_en | input | 1 | 1 = link integrity test active |
| cfg_pulse_tx_en | input | 1 | 1 = link pulse requests allowed |
| cfg_auto_pol_en | input | 1 | 1 = automatic polarity correction allowed |
| rx_pulse_vld | input | 1 | Link pulse detected this cycle |
| rx_pulse_neg | input | 1 | Raw polarity of that pulse, 1 = inverted |
| rx_pkt_end | input | 1 | Packet ended on a valid delimiter this cycle |
| rx_pkt_neg | input | 1 | Raw polarity of that delimiter, 1 = inverted |
| tx_active | input | 1 | Port is transmitting a packet |
| link_pass | output | 1 | 1 = link pass, 0 = link fail |
| pol_correct | output | 1 | 1 = true polarity, 0 = receive path inverted |
| trx_enable | output | 1 | Transmit and receive allowed on the port |
| lp_tx_req | output | 1 | One-cycle request to send a link pulse |

## Verification
The bench targets the following corner cases:
- A pulse run one short of the threshold, then a run broken by a single opposite pulse. A counter that did not restart would recover the link too early.
- The last edge of the silence window, with a wrong-polarity pulse placed inside it. A monitor that accepted any pulse would never time out, and an off-by-one in the window would move the drop by a cycle.
- A second packet after polarity has settled. A monitor that never disarmed would flip polarity on every packet.
- Toggling the link-test and auto-polarity controls.
- The exact request edge after transmit activity, including while the link is down.

// File: rtl/lim_pkg.sv
// Shared types for the link integrity monitor.
package lim_pkg;
    typedef enum logic {
        LINK_FAIL = 1'b0,
        LINK_PASS = 1'b1
    } link_state_e;
endpackage

// File: rtl/lim_pulse_sched.sv
// Outgoing link pulse scheduler.
// Counts clock edges of transmit silence and raises a one-cycle request each
// time IDLE_TICKS such edges have accumulated. Transmit activity or a
// disabled scheduler sets the count back to zero.
// Assumes IDLE_TICKS >= 2.
module lim_pulse_sched #(
    parameter int IDLE_TICKS = 320000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tx_active,
    output logic req
);
    localparam int W = $clog2(IDLE_TICKS + 1);
    localparam logic [W-1:0] LAST = W'(IDLE_TICKS - 1);

    logic [W-1:0] idle_cnt;

    // Idle counter and registered request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            req      <= 1'b0;
        end else if (!enable || tx_active) begin
            idle_cnt <= '0;
            req      <= 1'b0;
        end else if (idle_cnt == LAST) begin
            idle_cnt <= '0;
            req      <= 1'b1;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
            req      <= 1'b0;
        end
    end
endmodule

// File: rtl/lim_pulse_counter.sv
// Consecutive same-polarity link pulse counter, used while the link is down.
// A pulse whose polarity matches the previous one extends the run. Any other
// pulse starts a new run at 1. The hit output goes high in the cycle in which
// the arriving pulse completes a run of THRESH. The run is cleared while
// clear is high.
// Assumes THRESH >= 1.
module lim_pulse_counter #(
    parameter int THRESH = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic pulse_vld,
    input  logic pulse_neg,
    output logic hit
);
    localparam int W = $clog2(THRESH + 1);
    localparam logic [W-1:0] TH  = W'(THRESH);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] run_cnt;
    logic [W-1:0] run_nxt;
    logic         run_neg;

    // Length of the run after the current pulse, saturating at the threshold.
    always_comb begin
        if (run_cnt != '0 && pulse_neg == run_neg) begin
            run_nxt = (run_cnt == TH) ? run_cnt : run_cnt + 1'b1;
        end else begin
            run_nxt = ONE;
        end
    end

    assign hit = pulse_vld && !clear && (run_nxt == TH);

    // Run length and the polarity of the last pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            run_cnt <= '0;
            run_neg <= 1'b0;
        end else if (pulse_vld) begin
            run_cnt <= run_nxt;
            run_neg <= pulse_neg;
        end
    end
endmodule

// File: rtl/lim_link_ctrl.sv
// Link state, silence window and receive polarity correction.
// In pass: valid activity restarts a silence counter, and when the counter
// expires the port falls to fail and polarity detection re-arms.
// In fail: a packet end, or a completed pulse run reported by the run
// counter, restores pass and loads the polarity correction.
// Assumes FAIL_TICKS >= 2 and single-cycle event strobes.
module lim_link_ctrl
    import lim_pkg::*;
#(
    parameter int FAIL_TICKS = 1800000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        link_test_en,
    input  logic        auto_pol_en,
    input  logic        pulse_vld,
    input  logic        pulse_neg,
    input  logic        pkt_end,
    input  logic        pkt_neg,
    input  logic        run_hit,
    output link_state_e state,
    output logic        pol_flip
);
    localparam int W = $clog2(FAIL_TICKS + 1);
    localparam logic [W-1:0] LAST = W'(FAIL_TICKS - 1);

    logic [W-1:0] sil_cnt, sil_d;
    link_state_e  state_d;
    logic         flip_d;
    logic         armed, armed_d;
    logic         good_act;

    // Activity that counts as proof of a live link while in pass.
    assign good_act = pkt_end || (pulse_vld && (pulse_neg == pol_flip));

    // Next state, silence count, polarity and arming.
    always_comb begin
        state_d = state;
        sil_d   = sil_cnt;
        flip_d  = pol_flip;
        armed_d = armed;
        if (!link_test_en || state == LINK_PASS) begin
            if (pkt_end && armed) begin
                flip_d  = pkt_neg;
                armed_d = 1'b0;
            end
            if (!link_test_en) begin
                state_d = LINK_PASS;
                sil_d   = '0;
            end else if (good_act) begin
                sil_d = '0;
            end else if (sil_cnt == LAST) begin
                state_d = LINK_FAIL;
                sil_d   = '0;
                armed_d = 1'b1;
            end else begin
                sil_d = sil_cnt + 1'b1;
            end
        end else if (pkt_end) begin
            state_d = LINK_PASS;
            flip_d  = pkt_neg;
            armed_d = 1'b0;
            sil_d   = '0;
        end else if (run_hit) begin
            state_d = LINK_PASS;
            flip_d  = pulse_neg;
            sil_d   = '0;
        end
        if (!auto_pol_en) begin
            flip_d = 1'b0;
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= LINK_FAIL;
            sil_cnt  <= '0;
            pol_flip <= 1'b0;
            armed    <= 1'b1;
        end else begin
            state    <= state_d;
            sil_cnt  <= sil_d;
            pol_flip <= flip_d;
            armed    <= armed_d;
        end
    end
endmodule

// File: rtl/link_integrity_monitor.sv
// Top of the per-port link integrity and polarity monitor.
// Ties together the transmit pulse scheduler, the fail-state pulse run
// counter and the link/polarity controller. Link test disable overrides the
// reported status at once. All receive inputs are single-cycle strobes that
// are already synchronous to clk.
module link_integrity_monitor
    import lim_pkg::*;
#(
    parameter int IDLE_TICKS   = 320000,
    parameter int FAIL_TICKS   = 1800000,
    parameter int PULSE_THRESH = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_link_test_en,
    input  logic cfg_pulse_tx_en,
    input  logic cfg_auto_pol_en,
    input  logic rx_pulse_vld,
    input  logic rx_pulse_neg,
    input  logic rx_pkt_end,
    input  logic rx_pkt_neg,
    input  logic tx_active,
    output logic link_pass,
    output logic pol_correct,
    output logic trx_enable,
    output logic lp_tx_req
);
    link_state_e state;
    logic        pol_flip;
    logic        run_hit;

    lim_pulse_sched #(.IDLE_TICKS(IDLE_TICKS)) i_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cfg_pulse_tx_en),
        .tx_active (tx_active),
        .req       (lp_tx_req)
    );

    lim_pulse_counter #(.THRESH(PULSE_THRESH)) i_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state == LINK_PASS),
        .pulse_vld (rx_pulse_vld),
        .pulse_neg (rx_pulse_neg),
        .hit       (run_hit)
    );

    lim_link_ctrl #(.FAIL_TICKS(FAIL_TICKS)) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .link_test_en (cfg_link_test_en),
        .auto_pol_en  (cfg_auto_pol_en),
        .pulse_vld    (rx_pulse_vld),
        .pulse_neg    (rx_pulse_neg),
        .pkt_end      (rx_pkt_end),
        .pkt_neg      (rx_pkt_neg),
        .run_hit      (run_hit),
        .state        (state),
        .pol_flip     (pol_flip)
    );

    // Reported status, with the link test override applied.
    assign link_pass   = (state == LINK_PASS) || !cfg_link_test_en;
    assign trx_enable  = link_pass;
    assign pol_correct = !pol_flip;
endmodule

// File: rtl/lim_checker.sv
// Temporal checks on the link integrity monitor ports, bound to the top.
module lim_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_link_test_en,
    input logic cfg_pulse_tx_en,
    input logic cfg_auto_pol_en,
    input logic rx_pulse_vld,
    input logic rx_pkt_end,
    input logic tx_active,
    input logic link_pass,
    input logic pol_correct,
    input logic trx_enable,
    input logic lp_tx_req
);
    // R2
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lp_tx_req |=> !lp_tx_req);
    // R2
    req_after_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |=> !lp_tx_req);
    // R3
    req_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_pulse_tx_en |=> !lp_tx_req);
    // R5
    pass_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_link_test_en && $past(cfg_link_test_en) && $rose(link_pass))
        |-> $past(rx_pkt_end || rx_pulse_vld));
    // R7
    pol_change_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pol_correct) |-> $past(rx_pkt_end || rx_pulse_vld || !cfg_auto_pol_en));
    // R10
    inhibit_needs_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trx_enable |-> cfg_link_test_en);
    // R11
    auto_off_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_auto_pol_en |=> pol_correct);
endmodule

bind link_integrity_monitor lim_checker i_lim_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_link_test_en (cfg_link_test_en),
    .cfg_pulse_tx_en  (cfg_pulse_tx_en),
    .cfg_auto_pol_en  (cfg_auto_pol_en),
    .rx_pulse_vld     (rx_pulse_vld),
    .rx_pkt_end       (rx_pkt_end),
    .tx_active        (tx_active),
    .link_pass        (link_pass),
    .pol_correct      (pol_correct),
    .trx_enable       (trx_enable),
    .lp_tx_req        (lp_tx_req)
);

// File: tb/test_link_integrity_monitor.sv
`timescale 1ns/1ps
module test_link_integrity_monitor;
    localparam int IDLE = 40;
    localparam int FAIL = 150;
    localparam int TH   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lte = 1'b1, pte = 1'b1, ape = 1'b1;
    logic pv = 1'b0, pn = 1'b0, pe = 1'b0, pkn = 1'b0, txa = 1'b0;
    logic link_pass, pol_correct, trx_enable, lp_tx_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    link_integrity_monitor #(.IDLE_TICKS(IDLE), .FAIL_TICKS(FAIL), .PULSE_THRESH(TH))
    i_link_integrity_monitor (
        .clk(clk), .rst_n(rst_n),
        .cfg_link_test_en(lte), .cfg_pulse_tx_en(pte), .cfg_auto_pol_en(ape),
        .rx_pulse_vld(pv), .rx_pulse_neg(pn), .rx_pkt_end(pe), .rx_pkt_neg(pkn),
        .tx_active(txa),
        .link_pass(link_pass), .pol_correct(pol_correct),
        .trx_enable(trx_enable), .lp_tx_req(lp_tx_req)
    );

    // Reference model state, written from the requirements.
    bit m_pass, m_flip, m_armed, m_req, m_plast;
    int m_sil, m_pcnt, m_icnt;

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update at every clock edge.
    always @(posedge clk) begin
        bit hit, act;
        int np;
        if (!rst_n) begin
            m_pass = 0; m_flip = 0; m_armed = 1; m_req = 0; m_plast = 0;
            m_sil = 0; m_pcnt = 0; m_icnt = 0;
        end else begin
            if (!pte || txa) begin m_icnt = 0; m_req = 0; end
            else if (m_icnt == IDLE - 1) begin m_icnt = 0; m_req = 1; end
            else begin m_icnt++; m_req = 0; end
            hit = 0;
            if (m_pass) begin m_pcnt = 0; m_plast = 0; end
            else if (pv) begin
                np = (m_pcnt != 0 && pn == m_plast) ? ((m_pcnt >= TH) ? TH : m_pcnt + 1) : 1;
                hit = (np == TH);
                m_pcnt = np; m_plast = pn;
            end
            if (!lte || m_pass) begin
                act = pe || (pv && pn == m_flip);
                if (pe && m_armed) begin m_flip = pkn; m_armed = 0; end
                if (!lte) begin m_pass = 1; m_sil = 0; end
                else if (act) m_sil = 0;
                else if (m_sil == FAIL - 1) begin m_pass = 0; m_sil = 0; m_armed = 1; end
                else m_sil++;
            end else if (pe) begin
                m_pass = 1; m_flip = pkn; m_armed = 0; m_sil = 0;
            end else if (hit) begin
                m_pass = 1; m_flip = pn; m_sil = 0;
            end
            if (!ape) m_flip = 0;
        end
    end

    // Cycle-by-cycle comparison against the model, away from the edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 lp_tx_req", lp_tx_req, m_req);
            chk("R4 link_pass", link_pass, m_pass | ~lte);
            chk("R10 trx_enable", trx_enable, m_pass | ~lte);
            chk("R7 pol_correct", pol_correct, ~m_flip);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic neg);
        pv = 1; pn = neg; @(negedge clk); pv = 0; pn = 0;
    endtask

    task automatic packet(input logic neg);
        pe = 1; pkn = neg; @(negedge clk); pe = 0; pkn = 0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        int seen;
        void'($urandom(32'h1D5A_0E71));
        idle(3);
        rst_n = 1'b1;
        #1;
        // R1 reset values
        chk("R1 link_pass", link_pass, 1'b0);
        chk("R1 trx_enable", trx_enable, 1'b0);
        chk("R1 pol_correct", pol_correct, 1'b1);
        chk("R1 lp_tx_req", lp_tx_req, 1'b0);

        // R5: one short of the threshold, then a broken run
        repeat (TH - 1) begin pulse(1'b0); idle(2); end
        chk("R5 short run", link_pass, 1'b0);
        pulse(1'b1);
        repeat (TH - 2) begin pulse(1'b1); idle(1); end
        chk("R5 restart", link_pass, 1'b0);
        pulse(1'b1);
        chk("R5 run done", link_pass, 1'b1);
        chk("R7 inverted run", pol_correct, 1'b0);

        // R8: first packet while armed settles polarity, the next does not
        packet(1'b0);
        chk("R8 armed packet", pol_correct, 1'b1);
        packet(1'b1);
        chk("R8 disarmed packet", pol_correct, 1'b1);

        // R9 and R4: wrong-polarity pulse inside the window is ignored
        pulse(1'b0);
        idle(99);
        pulse(1'b1);
        idle(FAIL - 101);
        chk("R9 last window cycle", link_pass, 1'b1);
        idle(1);
        chk("R4 window expired", link_pass, 1'b0);
        chk("R4 inhibit", trx_enable, 1'b0);

        // R6: packet recovers the link
        packet(1'b0);
        chk("R6 packet exit", link_pass, 1'b1);

        // R10: link test disabled overrides a failed link
        idle(FAIL + 2);
        chk("R4 fail again", link_pass, 1'b0);
        lte = 1'b0;
        #1;
        chk("R10 immediate", link_pass, 1'b1);
        chk("R10 trx", trx_enable, 1'b1);
        idle(5);
        chk("R10 held", link_pass, 1'b1);
        lte = 1'b1;

        // R11: auto-polarity off keeps true polarity across a pulse exit
        idle(FAIL + 2);
        ape = 1'b0;
        repeat (TH) begin pulse(1'b1); idle(1); end
        chk("R11 exit", link_pass, 1'b1);
        chk("R11 pol true", pol_correct, 1'b1);
        ape = 1'b1;

        // R2 and R3: request timing while the link is down
        idle(FAIL + 2);
        chk("R3 in fail", link_pass, 1'b0);
        txa = 1'b1; @(negedge clk); txa = 1'b0;
        idle(IDLE - 1);
        chk("R2 before", lp_tx_req, 1'b0);
        idle(1);
        chk("R3 request in fail", lp_tx_req, 1'b1);
        idle(1);
        chk("R2 one cycle", lp_tx_req, 1'b0);
        pte = 1'b0;
        seen = 0;
        repeat (3 * IDLE) begin @(negedge clk); if (lp_tx_req) seen++; end
        chk("R3 disabled", seen != 0, 1'b0);
        pte = 1'b1;

        // Random segments against the model
        for (int seg = 0; seg < 10; seg++) begin
            lte = ($urandom % 5) != 0;
            pte = ($urandom % 4) != 0;
            ape = ($urandom % 4) != 0;
            for (int c = 0; c < 500; c++) begin
                pv  = ($urandom % (4 + seg * 8)) == 0;
                pn  = ($urandom % 4) == 0;
                pe  = ($urandom % (30 + seg * 40)) == 0;
                pkn = $urandom % 2;
                txa = ($urandom % (8 + seg * 20)) == 0;
                @(negedge clk);
            end
        end
        pv = 0; pe = 0; txa = 0;
        idle(2);
        finish_run();
    end
endmodule